// File: doc/BRIEF.md
# Edge-Gated Counter with One-Shot Delay

This block is a single timer channel that counts cycles of a primary count-enable stream. Counting is gated by a secondary input. When the trigger mode is selected, the first active edge of the secondary input starts the count. Each further active edge flips the count between paused and running. The sequence ends when the counter reaches a programmed compare value. A one-cycle compare pulse then marks the match, and every later edge is ignored until the channel is re-armed by writing the mode.

The secondary input is treated as asynchronous. It passes through a two-stage synchronizer and an edge register, and a polarity select chooses rising or falling edges as the active ones. A length enable reloads the counter to zero at the match instead of holding it. With the once bit set and the delay output mode selected, a single trigger starts an uninterruptible run. The run ends by raising a sticky output flag, which gives a programmable delay from the trigger to the flag.

Top module: `edge_gate_timer`

## Requirements
- R1: While rst_ni is low and after its release, count_o is 0, cmp_o is 0 and flag_o is 0.
- R2: When mode_i is not 3'b110, count_o does not change (except the clear of R11), and cmp_o and flag_o stay 0, whatever sec_i and cnt_en_i do.
- R3: In mode 3'b110 the first active edge of sec_i starts counting. Suppose the new sec_i level is first sampled at clock edge 1. The first increment can then occur at clock edge 4, and count_o then rises by one for each clock edge at which cnt_en_i is high.
- R4: With inv_i = 0 only rising edges of sec_i are active. With inv_i = 1 only falling edges are active. Edges of the other direction have no effect on count_o.
- R5: Before the match, the 2nd, 4th, 6th ... active edges stop counting, and the 3rd, 5th ... active edges restart it from the held value.
- R6: A match occurs on a counting clock edge at which count_o + 1 equals cmp_val_i (modulo 2^16). At that edge cmp_o goes high for exactly one cycle and the sequence ends. With len_i = 0, count_o then holds cmp_val_i, and no later edge restarts counting.
- R7: With len_i = 1, count_o becomes 0 at the same clock edge at which cmp_o goes high.
- R8: One-shot operation applies when mode_i = 3'b110, len_i = 1, omode_i = 3'b101 and once_i = 1. In that case flag_o rises together with cmp_o and stays high.
- R9: In one-shot operation, active edges after the starting edge do not pause the count before the match.
- R10: When the one-shot conditions of R8 do not all hold, flag_o stays 0 even at a match.
- R11: At the clock edge where mode_i differs from its value at the previous edge, count_o, cmp_o, flag_o and the sequence state are all cleared. A new sequence can then be started.
- R12: If a match and an active edge fall on the same clock edge, the match wins and the edge is dropped.
- R13: count_o never changes at a clock edge where cnt_en_i is low, except for a clear to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cnt_en_i | input | 1 | Primary count enable, one count per enabled cycle |
| sec_i | input | 1 | Asynchronous secondary gating input |
| cmp_val_i | input | 16 | Compare value |
| inv_i | input | 1 | 1 selects falling edges of sec_i as active |
| mode_i | input | 3 | Mode select, 3'b110 is the trigger mode |
| len_i | input | 1 | Reload counter to 0 at match |
| once_i | input | 1 | Once bit for one-shot operation |
| omode_i | input | 3 | Output-mode select, 3'b101 is the delay flag mode |
| count_o | output | 16 | Counter value |
| cmp_o | output | 1 | One-cycle compare event pulse |
| flag_o | output | 1 | Sticky one-shot delay flag |

## Verification
The match and an active secondary edge can land on the same clock edge. This happens when the edge that would pause the count is seen on the counting cycle that reaches the compare value. The bench provokes the case by re-arming the channel many times and shifting the stopping edge one cycle at a time across the match cycle, so one of the offsets hits the match edge exactly. A behavioural reference model judges every cycle. It expects the count to freeze at the compare value with a single compare pulse, and no restart on later edges.

// File: rtl/edge_gate_timer_pkg.sv
package edge_gate_timer_pkg;
  localparam int unsigned MODE_W  = 3;
  localparam int unsigned OMODE_W = 3;
  localparam logic [MODE_W-1:0]  MODE_TRIG   = 3'b110;
  localparam logic [OMODE_W-1:0] OMODE_DELAY = 3'b101;

  typedef struct packed {
    logic run;
    logic done;
    logic flag;
  } gate_state_t;
endpackage

// File: rtl/edge_sync.sv
module edge_sync #(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sig_i,
  input  logic inv_i,
  output logic edge_o
);
  logic [SYNC_STAGES-1:0] stage_q;
  logic                   prev_q;

  for (genvar g = 0; g < SYNC_STAGES; g++) begin : g_stage
    if (g == 0) begin : g_first
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) stage_q[g] <= 1'b0;
        else         stage_q[g] <= sig_i;
      end
    end else begin : g_next
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) stage_q[g] <= 1'b0;
        else         stage_q[g] <= stage_q[g-1];
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= 1'b0;
    else         prev_q <= stage_q[SYNC_STAGES-1];
  end

  // level changed and new level is the active one
  assign edge_o = (stage_q[SYNC_STAGES-1] ^ prev_q) & (stage_q[SYNC_STAGES-1] ^ inv_i);
endmodule

// File: rtl/gate_ctrl.sv
module gate_ctrl
  import edge_gate_timer_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic trig_i,
  input  logic oneshot_i,
  input  logic clr_i,
  input  logic edge_i,
  input  logic hit_i,
  output logic run_o,
  output logic flag_o
);
  gate_state_t st_q, st_d;

  always_comb begin
    st_d = st_q;
    if (clr_i) begin
      st_d = '0;
    end else if (!trig_i) begin
      st_d.run  = 1'b0;
      st_d.done = 1'b0;
    end else if (hit_i) begin
      // match has priority over a same-cycle edge
      st_d.run  = 1'b0;
      st_d.done = 1'b1;
      st_d.flag = st_q.flag | oneshot_i;
    end else if (edge_i && !st_q.done) begin
      st_d.run = oneshot_i ? 1'b1 : ~st_q.run;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) st_q <= '0;
    else         st_q <= st_d;
  end

  assign run_o  = st_q.run;
  assign flag_o = st_q.flag;
endmodule

// File: rtl/count_core.sv
module count_core #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             clr_i,
  input  logic             reload_i,
  input  logic [CNT_W-1:0] cmp_val_i,
  output logic [CNT_W-1:0] count_o,
  output logic             hit_o,
  output logic             cmp_o
);
  logic [CNT_W-1:0] count_q, count_inc;
  logic             cmp_q;

  assign count_inc = count_q + CNT_W'(1);
  assign hit_o     = tick_i & (count_inc == cmp_val_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      count_q <= '0;
      cmp_q   <= 1'b0;
    end else if (clr_i) begin
      count_q <= '0;
      cmp_q   <= 1'b0;
    end else begin
      cmp_q <= hit_o;
      if (tick_i) count_q <= (hit_o && reload_i) ? '0 : count_inc;
    end
  end

  assign count_o = count_q;
  assign cmp_o   = cmp_q;
endmodule

// File: rtl/edge_gate_timer.sv
module edge_gate_timer
  import edge_gate_timer_pkg::*;
#(
  parameter int unsigned CNT_W       = 16,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               cnt_en_i,
  input  logic               sec_i,
  input  logic [CNT_W-1:0]   cmp_val_i,
  input  logic               inv_i,
  input  logic [MODE_W-1:0]  mode_i,
  input  logic               len_i,
  input  logic               once_i,
  input  logic [OMODE_W-1:0] omode_i,
  output logic [CNT_W-1:0]   count_o,
  output logic               cmp_o,
  output logic               flag_o
);
  logic [MODE_W-1:0] mode_q;
  logic trig, oneshot, clr, act_edge, run, tick, hit;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) mode_q <= '0;
    else         mode_q <= mode_i;
  end

  assign trig    = (mode_i == MODE_TRIG);
  assign oneshot = trig & len_i & once_i & (omode_i == OMODE_DELAY);
  assign clr     = (mode_i != mode_q);
  assign tick    = trig & run & cnt_en_i;

  edge_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .sig_i (sec_i),
    .inv_i (inv_i),
    .edge_o(act_edge)
  );

  gate_ctrl u_ctrl (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .trig_i   (trig),
    .oneshot_i(oneshot),
    .clr_i    (clr),
    .edge_i   (act_edge),
    .hit_i    (hit),
    .run_o    (run),
    .flag_o   (flag_o)
  );

  count_core #(.CNT_W(CNT_W)) u_core (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .tick_i   (tick),
    .clr_i    (clr),
    .reload_i (len_i),
    .cmp_val_i(cmp_val_i),
    .count_o  (count_o),
    .hit_o    (hit),
    .cmp_o    (cmp_o)
  );
endmodule

// File: rtl/edge_gate_timer_chk.sv
module edge_gate_timer_chk
  import edge_gate_timer_pkg::*;
#(
  parameter int unsigned CNT_W = 16
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               cnt_en_i,
  input logic               len_i,
  input logic [MODE_W-1:0]  mode_i,
  input logic [CNT_W-1:0]   count_o,
  input logic               cmp_o,
  input logic               flag_o
);
  assert_cmp_single_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmp_o |=> !cmp_o);

  assert_len_reload_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmp_o && $past(len_i)) |-> (count_o == '0));

  assert_idle_hold_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(mode_i) != MODE_TRIG) |-> (!cmp_o && (count_o == '0 || $stable(count_o))));

  assert_flag_sticky_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flag_o |=> (flag_o || ($past(mode_i) != $past(mode_i, 2))));

  assert_flag_at_match_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(flag_o) |-> cmp_o);

  assert_step_on_enable_R13: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((count_o != $past(count_o)) && (count_o != '0)) |->
      ($past(cnt_en_i) && (count_o == $past(count_o) + CNT_W'(1))));
endmodule

bind edge_gate_timer edge_gate_timer_chk #(.CNT_W(CNT_W)) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .cnt_en_i(cnt_en_i),
  .len_i   (len_i),
  .mode_i  (mode_i),
  .count_o (count_o),
  .cmp_o   (cmp_o),
  .flag_o  (flag_o)
);

// File: tb/edge_gate_timer_tb.sv
`timescale 1ns/1ps
module edge_gate_timer_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cnt_en = 1'b0;
  logic        sec = 1'b0;
  logic [15:0] cmp_val = 16'd0;
  logic        inv = 1'b0;
  logic [2:0]  mode = 3'b000;
  logic        len = 1'b0;
  logic        once = 1'b0;
  logic [2:0]  omode = 3'b000;
  logic [15:0] count;
  logic        cmp;
  logic        flag;

  int    total = 0;
  int    bad = 0;
  string cur_req = "R1";
  bit    checking = 1'b0;
  int    cmp_seen = 0;

  always #2 clk = ~clk;

  edge_gate_timer u_dut (
    .clk_i(clk), .rst_ni(rst_n), .cnt_en_i(cnt_en), .sec_i(sec),
    .cmp_val_i(cmp_val), .inv_i(inv), .mode_i(mode), .len_i(len),
    .once_i(once), .omode_i(omode), .count_o(count), .cmp_o(cmp), .flag_o(flag)
  );

  // reference model
  int m_cnt, m_cmp, m_flag, m_run, m_done, m_mode_q;
  int h0, h1, h2;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_cnt = 0; m_cmp = 0; m_flag = 0; m_run = 0; m_done = 0; m_mode_q = 0;
      h0 = 0; h1 = 0; h2 = 0;
    end else begin
      bit e, trg, os, clr, tk, ht;
      e   = inv ? (h1 == 0 && h2 == 1) : (h1 == 1 && h2 == 0);
      trg = (mode == 3'b110);
      os  = trg && len && once && (omode == 3'b101);
      clr = (int'(mode) != m_mode_q);
      tk  = trg && (m_run != 0) && cnt_en;
      ht  = tk && (((m_cnt + 1) % 65536) == int'(cmp_val));
      if (clr) begin
        m_cnt = 0; m_cmp = 0; m_flag = 0; m_run = 0; m_done = 0;
      end else begin
        m_cmp = ht;
        if (tk) m_cnt = (ht && len) ? 0 : (m_cnt + 1) % 65536;
        if (!trg) begin
          m_run = 0; m_done = 0;
        end else if (ht) begin
          m_run = 0; m_done = 1;
          if (os) m_flag = 1;
        end else if (e && m_done == 0) begin
          m_run = os ? 1 : (m_run == 0);
        end
      end
      m_mode_q = int'(mode);
      h2 = h1; h1 = h0; h0 = int'(sec);
    end
  end

  task automatic check(input bit ok, input string req, input string what, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  always @(posedge clk) begin
    #1;
    if (rst_n && checking) begin
      if (cmp) cmp_seen++;
      check(int'(count) == m_cnt, cur_req, "count", int'(count), m_cnt);
      check(int'(cmp) == m_cmp, cur_req, "cmp", int'(cmp), m_cmp);
      check(int'(flag) == m_flag, cur_req, "flag", int'(flag), m_flag);
    end
  end

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic rearm();
    mode = 3'b000; cyc(1);
    mode = 3'b110; cyc(1);
  endtask

  task automatic set_sec(input bit v, input int hold);
    sec = v; cyc(hold);
  endtask

  initial begin
    #400000;
    bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    cyc(3);
    cur_req = "R1";
    check(count == 16'd0 && !cmp && !flag, "R1", "reset outputs", int'(count), 0);
    rst_n = 1'b1;
    cyc(1);
    checking = 1'b1;
    cyc(2);

    // idle mode ignores everything
    cur_req = "R2";
    cnt_en = 1'b1; cmp_val = 16'd5;
    for (int i = 0; i < 3; i++) begin set_sec(1, 4); set_sec(0, 4); end
    check(count == 16'd0, "R2", "count idle", int'(count), 0);

    // start, enable pattern
    cur_req = "R3";
    cmp_val = 16'd300;
    rearm();
    cnt_en = 1'b1;
    sec = 1'b1;
    @(negedge clk);
    @(negedge clk);
    @(negedge clk);
    check(count == 16'd0, "R3", "no count before edge 4", int'(count), 0);
    @(negedge clk);
    check(count == 16'd1, "R3", "first increment at edge 4", int'(count), 1);
    cur_req = "R13";
    for (int i = 0; i < 24; i++) begin cnt_en = (i % 3) != 1; cyc(1); end
    cnt_en = 1'b1;

    // toggling: falling is inactive, rising stops/restarts
    cur_req = "R5";
    set_sec(0, 6);
    set_sec(1, 8);
    set_sec(0, 6);
    set_sec(1, 8);
    set_sec(0, 4);
    set_sec(1, 8);
    set_sec(0, 4);

    // compare end, later edges ignored
    cur_req = "R6";
    cmp_val = 16'd20; len = 1'b0;
    rearm();
    set_sec(1, 30);
    check(count == 16'd20, "R6", "hold at compare", int'(count), 20);
    for (int i = 0; i < 3; i++) begin set_sec(0, 4); set_sec(1, 4); end
    check(count == 16'd20, "R6", "edges after match", int'(count), 20);
    set_sec(0, 4);

    // reload
    cur_req = "R7";
    len = 1'b1; cmp_val = 16'd12;
    rearm();
    set_sec(1, 25);
    set_sec(0, 4);
    len = 1'b0;

    // inverted polarity
    cur_req = "R4";
    mode = 3'b000; inv = 1'b1; sec = 1'b1; cyc(6);
    cmp_val = 16'd200;
    mode = 3'b110; cyc(2);
    set_sec(0, 8);
    set_sec(1, 8);
    set_sec(0, 8);
    set_sec(1, 8);
    mode = 3'b000; inv = 1'b0; sec = 1'b0; cyc(6);

    // one-shot: pauses ignored, flag at match
    cur_req = "R9";
    len = 1'b1; once = 1'b1; omode = 3'b101; cmp_val = 16'd25;
    rearm();
    set_sec(1, 6);
    set_sec(0, 4);
    set_sec(1, 6);
    cur_req = "R8";
    set_sec(0, 30);
    check(flag == 1'b1, "R8", "flag after match", int'(flag), 1);
    cyc(5);
    check(flag == 1'b1, "R8", "flag sticky", int'(flag), 1);

    // mode rewrite clears flag
    cur_req = "R11";
    rearm();
    check(flag == 1'b0 && count == 16'd0, "R11", "cleared by rewrite", int'(flag), 0);
    set_sec(1, 32);
    check(flag == 1'b1, "R11", "restart after clear", int'(flag), 1);
    set_sec(0, 4);

    // not all one-shot conditions
    cur_req = "R10";
    omode = 3'b100;
    rearm();
    set_sec(1, 32);
    check(flag == 1'b0, "R10", "no flag outside one-shot", int'(flag), 0);
    set_sec(0, 4);
    omode = 3'b000; once = 1'b0; len = 1'b0;

    // edge vs match on the same cycle: sweep stop edge offset
    cur_req = "R12";
    cmp_val = 16'd10;
    for (int d = 5; d <= 14; d++) begin
      cmp_seen = 0;
      rearm();
      sec = 1'b1; cyc(d);
      sec = 1'b0; cyc(2);
      sec = 1'b1; cyc(12);
      sec = 1'b0; cyc(4);
      sec = 1'b1; cyc(12);
      check(cmp_seen <= 1, "R12", "single compare pulse", cmp_seen, 1);
      sec = 1'b0; cyc(4);
    end

    checking = 1'b0;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule